// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers interrupt events for a small 8-bit processor core and turns them into a single request line. Three core events (timer rollover, external pin edge, port pin change) and a parameterised number of peripheral events each latch into a flag bit. A flag bit is latched whether or not anything enables it, so software can poll it. A flag reaches the processor only when several conditions hold together:

- its own enable bit is set;
- for peripheral sources, the peripheral-group enable bit is also set;
- the master enable bit is set.

The processor takes an interrupt with an acknowledge strobe. The controller then drops the master enable and presents a fixed vector address. A return strobe raises the master enable again. A separate wake line reports pending work regardless of the master enable, so the device can leave a low-power state.

Software reaches everything through a simple register port. The port gives one 8-bit core control register, plus one flag register and one enable register for every bank of peripheral sources. Flags are cleared only by writing them.

Top module: `intr_hub`

## Requirements
- R1: After reset every register reads 0, and `irq_req` and `wake` are 0.
- R2: The core register at address 0 holds, from bit 7 down to bit 0: master enable, peripheral-group enable, timer enable, pin enable, port-change enable, timer flag, pin flag, port-change flag. Every bit can be written and read back. Unmapped addresses read 0.
- R3: An event pulse sets its flag on the next clock edge, whatever the enables hold. `core_evt` bit 2 drives the timer flag, bit 1 the pin flag and bit 0 the port-change flag. `periph_evt` bit 8k+j drives bit j of flag bank k.
- R4: When an event and a software write hit the same flag in the same cycle, the flag ends up set.
- R5: A peripheral flag can raise a request only while the peripheral-group enable is set.
- R6: `irq_req` is registered. It is 1 in the cycle after one where the master enable was set and at least one enabled flag passed its gating, unless that cycle carried an acknowledge or a write clearing the master enable.
- R7: An acknowledge clears the master enable on the next edge. `irq_vector` always reads 0x0004.
- R8: A return strobe without an acknowledge sets the master enable, so a flag still pending raises `irq_req` again.
- R9: A write that clears the master enable forces `irq_req` to 0 in the following cycle. The flags stay pending and are served once the master enable is set again.
- R10: Flags change only through an event or a software write.
- R11: `wake` is 1 whenever an enabled flag passes its gating, even with the master enable clear.
- R12: Peripheral bank k has its flag register at address 1+2k and its enable register at address 2+2k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_evt | input | 3 | Core event pulses: timer, pin, port change |
| periph_evt | input | NBANK*BANK_W | Peripheral event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq_ack | input | 1 | Processor accepts the interrupt |
| irq_ret | input | 1 | Processor returns from the handler |
| irq_req | output | 1 | Registered interrupt request |
| irq_vector | output | VEC_W | Handler entry address |
| wake | output | 1 | Pending enabled work, ignores master enable |

## Verification
The bench aims at several races on purpose:

- An event and a write clearing the same flag in one cycle. A design that gives the write priority would lose an interrupt.
- A request that is already high when software clears the master enable. A design without the one-cycle suppression would dispatch once more after interrupts were meant to be off.
- An acknowledge and a return arriving in the same cycle.
- A flag left set across a return. This must trigger a repeat request.

It also confirms that peripheral flags wait on the group enable, and that wake ignores the master enable. Skipping either gate would show up as a spurious request, or as a missed wake-up.

// File: rtl/intr_pkg.sv
package intr_pkg;
   localparam int unsigned DATA_W    = 8;
   localparam int unsigned CORE_SRCS = 3;
   // core register bit positions (software decodes these)
   localparam int unsigned B_GIE  = 7;
   localparam int unsigned B_GRP  = 6;
   localparam int unsigned B_EN_H = 5;
   localparam int unsigned B_EN_L = 3;
   localparam int unsigned B_FL_H = 2;
   localparam int unsigned B_FL_L = 0;
endpackage

// File: rtl/intr_flag_reg.sv
module intr_flag_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = wr_en ? wr_data : q;
      nxt = nxt | evt;          // event wins over a clearing write
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((q & $past(evt)) == $past(evt)));
   p_evt_beats_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (evt != '0)) |=> ((q & $past(evt)) != '0));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && evt == '0) |=> $stable(q));
endmodule

// File: rtl/intr_bank.sv
module intr_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         flag_we,
   input  logic         en_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] flags,
   output logic [W-1:0] enables,
   output logic         pend
);
   intr_flag_reg #(.W(W)) u_flags (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .wr_en(flag_we), .wr_data(wdata), .q(flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     enables <= '0;
      else if (en_we) enables <= wdata;
   end

   assign pend = |(flags & enables);
endmodule

// File: rtl/intr_gie_ctl.sv
module intr_gie_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   input  logic ret,
   input  logic wr_en,
   input  logic wr_gie,
   input  logic pend_any,
   output logic gie,
   output logic req
);
   logic drop_now;
   assign drop_now = wr_en && !wr_gie;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie <= 1'b0;
         req <= 1'b0;
      end else begin
         req <= gie && pend_any && !ack && !drop_now;
         if (ack)        gie <= 1'b0;
         else if (ret)   gie <= 1'b1;
         else if (wr_en) gie <= wr_gie;
      end
   end

   p_req_needs_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> $past(gie));
   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (!gie && !req));
   p_ret_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && !ack) |=> gie);
   p_drop_suppress_r9: assert property (@(posedge clk) disable iff (!rst_n)
      drop_now |=> !req);
endmodule

// File: rtl/intr_hub.sv
module intr_hub
   import intr_pkg::*;
#(
   parameter int unsigned NBANK   = 2,
   parameter int unsigned BANK_W  = 8,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned VEC_W   = 13,
   parameter int unsigned VEC_VAL = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CORE_SRCS-1:0]    core_evt,
   input  logic [NBANK*BANK_W-1:0] periph_evt,
   input  logic                    reg_we,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   input  logic                    irq_ack,
   input  logic                    irq_ret,
   output logic                    irq_req,
   output logic [VEC_W-1:0]        irq_vector,
   output logic                    wake
);
   localparam int unsigned LAST_ADDR = 2 * NBANK;

   if (BANK_W == 0 || BANK_W > DATA_W) begin : g_bad_bank_w
      $error("BANK_W must be 1..DATA_W");
   end
   if ((1 << ADDR_W) <= LAST_ADDR) begin : g_bad_addr_w
      $error("ADDR_W too small for bank count");
   end
   if (VEC_VAL >= (1 << VEC_W)) begin : g_bad_vec
      $error("VEC_VAL does not fit VEC_W");
   end

   logic                 core_wr;
   logic [CORE_SRCS-1:0] core_flag;
   logic [CORE_SRCS-1:0] core_en;
   logic                 grp_en;
   logic                 gie;
   logic                 pend_any;
   logic [NBANK-1:0]     bank_pend;
   logic [BANK_W-1:0]    bank_f [NBANK];
   logic [BANK_W-1:0]    bank_e [NBANK];

   assign core_wr = reg_we && (reg_addr == '0);

   intr_flag_reg #(.W(CORE_SRCS)) u_core_flags (
      .clk(clk), .rst_n(rst_n), .evt(core_evt),
      .wr_en(core_wr), .wr_data(reg_wdata[B_FL_H:B_FL_L]), .q(core_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         core_en <= '0;
         grp_en  <= 1'b0;
      end else if (core_wr) begin
         core_en <= reg_wdata[B_EN_H:B_EN_L];
         grp_en  <= reg_wdata[B_GRP];
      end
   end

   for (genvar k = 0; k < NBANK; k++) begin : g_bank
      logic f_we, e_we;
      assign f_we = reg_we && (reg_addr == ADDR_W'(1 + 2*k));
      assign e_we = reg_we && (reg_addr == ADDR_W'(2 + 2*k));
      intr_bank #(.W(BANK_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .evt(periph_evt[k*BANK_W +: BANK_W]),
         .flag_we(f_we), .en_we(e_we),
         .wdata(reg_wdata[BANK_W-1:0]),
         .flags(bank_f[k]), .enables(bank_e[k]),
         .pend(bank_pend[k])
      );
   end

   assign pend_any = (|(core_flag & core_en)) | (grp_en && (|bank_pend));

   intr_gie_ctl u_gie (
      .clk(clk), .rst_n(rst_n), .ack(irq_ack), .ret(irq_ret),
      .wr_en(core_wr), .wr_gie(reg_wdata[B_GIE]),
      .pend_any(pend_any), .gie(gie), .req(irq_req)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == '0)
         reg_rdata = {gie, grp_en, core_en, core_flag};
      for (int k = 0; k < NBANK; k++) begin
         if (reg_addr == ADDR_W'(1 + 2*k)) reg_rdata = DATA_W'(bank_f[k]);
         if (reg_addr == ADDR_W'(2 + 2*k)) reg_rdata = DATA_W'(bank_e[k]);
      end
   end

   assign irq_vector = VEC_W'(VEC_VAL);
   assign wake       = pend_any;

   p_req_after_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(wake));
   p_grp_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp_en && (core_flag & core_en) == '0) |-> !wake);
endmodule

// File: tb/intr_hub_test.sv
module intr_hub_test;
   localparam int PERIOD = 10;
   localparam int NB = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  core_evt = '0;
   logic [15:0] periph_evt = '0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        irq_ack = 1'b0, irq_ret = 1'b0;
   logic        irq_req;
   logic [12:0] irq_vector;
   logic        wake;

   int total = 0, fails = 0;

   // reference state
   logic [7:0] m_core;
   logic [7:0] m_pf [NB];
   logic [7:0] m_pe [NB];
   logic       m_req;

   always #(PERIOD/2) clk = ~clk;

   intr_hub uut (
      .clk(clk), .rst_n(rst_n), .core_evt(core_evt), .periph_evt(periph_evt),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_req(irq_req), .irq_vector(irq_vector), .wake(wake)
   );

   task automatic check(string tag, int got, int exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic m_pend();
      logic p = |(m_core[2:0] & m_core[5:3]);
      logic g = 1'b0;
      for (int k = 0; k < NB; k++) g = g | (|(m_pf[k] & m_pe[k]));
      return p | (m_core[6] & g);
   endfunction

   function automatic logic [7:0] m_read(logic [3:0] a);
      if (a == 0) return m_core;
      for (int k = 0; k < NB; k++) begin
         if (a == 4'(1 + 2*k)) return m_pf[k];
         if (a == 4'(2 + 2*k)) return m_pe[k];
      end
      return 8'h00;
   endfunction

   task automatic model_reset();
      m_core = '0; m_req = 1'b0;
      for (int k = 0; k < NB; k++) begin m_pf[k] = '0; m_pe[k] = '0; end
   endtask

   task automatic clr_in();
      core_evt = '0; periph_evt = '0; reg_we = 0; irq_ack = 0; irq_ret = 0;
   endtask

   // one clock: advance the model with the inputs in force, then compare
   task automatic tick();
      logic cw;
      logic [7:0] nc;
      @(posedge clk);
      cw = reg_we && reg_addr == 0;
      m_req = m_core[7] & m_pend() & !irq_ack & !(cw && !reg_wdata[7]);
      nc = cw ? reg_wdata : m_core;
      nc[2:0] = nc[2:0] | core_evt;
      nc[7] = irq_ack ? 1'b0 : irq_ret ? 1'b1 : (cw ? reg_wdata[7] : m_core[7]);
      for (int k = 0; k < NB; k++) begin
         if (reg_we && reg_addr == 4'(1 + 2*k)) m_pf[k] = reg_wdata;
         if (reg_we && reg_addr == 4'(2 + 2*k)) m_pe[k] = reg_wdata;
         m_pf[k] = m_pf[k] | periph_evt[k*8 +: 8];
      end
      m_core = nc;
      #2;
      check("R6 irq_req", irq_req, m_req);
      check("R11 wake", wake, m_pend());
      check("R2 reg_rdata", reg_rdata, m_read(reg_addr));
      check("R7 irq_vector", irq_vector, 4);
      clr_in();
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      reg_we = 1; reg_addr = a; reg_wdata = d; tick();
   endtask

   task automatic rd(logic [3:0] a);
      reg_addr = a; #1;
   endtask

   initial begin
      #(PERIOD * 200000);
      fails++; total++;
      $display("FAIL watchdog: run did not finish, got timeout expected end");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R1 reset state
      for (int a = 0; a < 5; a++) begin rd(4'(a)); check("R1 reset reg", reg_rdata, 0); end
      check("R1 reset req", irq_req, 0);
      check("R1 reset wake", wake, 0);

      // R2 layout readback
      wr(0, 8'h38); rd(0); check("R2 enables readback", reg_rdata, 8'h38);
      wr(0, 8'h00);
      // R3 flags latch with all enables clear
      core_evt = 3'b100; tick(); core_evt = 3'b011; tick();
      rd(0); check("R3 core flags latched", reg_rdata, 8'h07);
      check("R3 no wake when masked", wake, 0);
      // R10 flags hold while idle
      repeat (4) tick();
      rd(0); check("R10 flags held", reg_rdata, 8'h07);
      // R4 event beats clearing write
      core_evt = 3'b010; wr(0, 8'h00);
      rd(0); check("R4 event wins", reg_rdata, 8'h02);
      // R11 wake with master enable clear
      wr(0, 8'h24); rd(0);
      check("R11 wake without gie", wake, 1);
      check("R11 no request without gie", irq_req, 0);
      // R6 request after enabling
      wr(0, 8'hA4); tick();
      check("R6 request raised", irq_req, 1);
      // R7 acknowledge
      irq_ack = 1; tick(); rd(0);
      check("R7 gie cleared by ack", reg_rdata, 8'h24);
      check("R7 req dropped", irq_req, 0);
      // R8 return with flag still set
      irq_ret = 1; tick(); tick();
      check("R8 repeat request", irq_req, 1);
      // R9 clearing write suppresses
      wr(0, 8'h24);
      check("R9 suppressed", irq_req, 0);
      rd(0); check("R9 flag pending", reg_rdata, 8'h24);
      wr(0, 8'hA4); tick();
      check("R9 served after re-enable", irq_req, 1);
      // R7/R8 same-cycle ack and return: ack wins
      irq_ack = 1; irq_ret = 1; tick(); rd(0);
      check("R7 ack over ret", reg_rdata[7], 0);

      // R5 peripheral group gating, R12 bank map
      wr(0, 8'h80);
      wr(2, 8'h01);
      periph_evt = 16'h0001; tick(); tick();
      rd(1); check("R12 bank0 flag", reg_rdata, 8'h01);
      check("R5 blocked without group enable", irq_req, 0);
      wr(0, 8'hC0); tick();
      check("R5 request with group enable", irq_req, 1);
      wr(4, 8'h5A); rd(4); check("R12 bank1 enable", reg_rdata, 8'h5A);
      periph_evt = 16'h8000; tick(); rd(3);
      check("R12 bank1 flag", reg_rdata, 8'h80);
      rd(5); check("R2 unmapped reads zero", reg_rdata, 0);
      wr(0, 8'h00); wr(1, 8'h00); wr(3, 8'h00);

      // mixed traffic against the model
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 7) == 0) begin
            reg_we = 1; reg_addr = 4'($urandom_range(0, 5)); reg_wdata = 8'($urandom);
         end else reg_addr = 4'($urandom_range(0, 5));
         if ($urandom_range(0, 5) == 0) core_evt = 3'($urandom);
         if ($urandom_range(0, 7) == 0) periph_evt = 16'(1 << $urandom_range(0, 15));
         irq_ack = irq_req && ($urandom_range(0, 2) == 0);
         irq_ret = ($urandom_range(0, 15) == 0);
         tick();
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule